// File: doc/BRIEF.md
# Quarter-Wave Sine Synthesizer Core

This core is a direct digital synthesis engine. A 16-bit tuning word sets the frequency. The word is summed into a 21-bit phase register on every second input clock, so the output frequency is f_clk × word / 2^22. The top bits of the phase pick one of 512 points around a full sine period. Only the first quarter of that period is stored, as 128 entries of 7 bits. The other three quarters are rebuilt in two steps: the table index is mirrored in the second half of each half-cycle, and the stored magnitude is flipped about midscale in the lower half-cycle. The result is an 8-bit offset-binary sample, ready for an external converter.

Two control inputs sit beside the datapath. An active-low sync input clears the phase and parks the sample at midscale while it is held low. This lets several cores that share a clock start in a known phase relation. A shutdown input also parks the sample at midscale, but it keeps the phase where it is, so the waveform carries on from that point with the last word once shutdown is released. A free-running divide-by-two clock output is provided for external logic.

Top module: `dds_sine_core`

## Requirements
- R1: While `rst` is high, and on the first edge after it is seen, `sample` is 0x80, `clk_half` is 0 and the phase is zero.
- R2: `clk_half` inverts on every rising edge of `clk` once reset is released.
- R3: The phase advances by `tune_word` only on an edge where `clk_half` is 1 just before that edge, so it advances once every two clocks. On other edges the phase is unchanged.
- R4: Phase bits [18:12] form a 7-bit index. When bit 19 is 1, the index is inverted before lookup. Entry k of the table is round(127 × sin((k + 0.5) × π/256)).
- R5: With phase bit 20 clear, the registered sample is 0x80 plus the table value. With bit 20 set, it is 0x7F minus the table value. The sample is registered one clock after the phase it comes from.
- R6: On an edge where `sync_n` is low, the phase is cleared and the next sample is 0x80. After `sync_n` returns high, samples start again from phase zero.
- R7: On an edge where `shutdown` is high and `sync_n` is high, the phase is held and the next sample is 0x80. After release, the waveform continues from the held phase with the current word.
- R8: When `sync_n` is low and `shutdown` is high on the same edge, sync wins: the phase is cleared.
- R9: The phase wraps modulo 2^21, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| tune_word | input | 16 | Phase increment per step |
| sync_n | input | 1 | Low: clear phase, hold output at midscale |
| shutdown | input | 1 | High: freeze phase, hold output at midscale |
| clk_half | output | 1 | Clock at half the input rate |
| sample | output | 8 | Offset-binary sine sample |

## Verification
Sync and shutdown can act on the same edge, and the release of sync can land on either a stepping or a non-stepping edge. The bench holds shutdown high while it pulses sync. It then releases sync one cycle at a time at shifted offsets relative to `clk_half`. A behavioural model checks, on every clock, that the phase restarts at zero and that the first step after restart falls on the correct edge.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int ACC_W  = 21;
    localparam int WORD_W = 16;
    localparam int ROM_AW = 7;
    localparam int ROM_DW = 7;

    typedef enum logic [1:0] {
        OUT_RUN  = 2'd0,
        OUT_SYNC = 2'd1,
        OUT_SHDN = 2'd2
    } out_mode_e;

    // Rounded quarter-wave magnitude at the centre of bin k, via a Taylor series.
    function automatic int quarter_sine(int k, int aw, int dw);
        real x;
        real term;
        real sum;
        real amp;
        x    = (real'(k) + 0.5) * 3.14159265358979 / (2.0 * real'(1 << aw));
        term = x;
        sum  = x;
        for (int n = 1; n < 10; n++) begin
            term = -term * x * x / real'((2 * n) * (2 * n + 1));
            sum  = sum + term;
        end
        amp = real'((1 << dw) - 1);
        return $rtoi(amp * sum + 0.5);
    endfunction

endpackage

// File: rtl/phase_accum.sv
module phase_accum #(
    parameter int ACC_W  = dds_pkg::ACC_W,
    parameter int WORD_W = dds_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              hold,
    input  logic              step_en,
    input  logic [WORD_W-1:0] word,
    output logic [ACC_W-1:0]  phase
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase <= '0;
        end else if (step_en && !hold) begin
            phase <= phase + ACC_W'(word);
        end
    end
endmodule

// File: rtl/quarter_rom.sv
module quarter_rom #(
    parameter int AW = dds_pkg::ROM_AW,
    parameter int DW = dds_pkg::ROM_DW
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] table_q [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam logic [DW-1:0] VAL = DW'(dds_pkg::quarter_sine(k, AW, DW));
        assign table_q[k] = VAL;
    end

    assign data = table_q[addr];
endmodule

// File: rtl/sine_shaper.sv
module sine_shaper #(
    parameter int AW = dds_pkg::ROM_AW,
    parameter int DW = dds_pkg::ROM_DW
) (
    input  logic                clk,
    input  logic                rst,
    input  dds_pkg::out_mode_e  mode,
    input  logic [AW+1:0]       phase_top,
    output logic [AW-1:0]       rom_addr,
    input  logic [DW-1:0]       rom_data,
    output logic [DW:0]         sample
);
    localparam int SW = DW + 1;
    localparam logic [SW-1:0] MID = SW'(1 << DW);

    logic          sign_bit;
    logic          quad_bit;
    logic [AW-1:0] raw_addr;
    logic [SW-1:0] shaped;

    assign sign_bit = phase_top[AW+1];
    assign quad_bit = phase_top[AW];
    assign raw_addr = phase_top[AW-1:0];
    assign rom_addr = quad_bit ? ~raw_addr : raw_addr;

    always_comb begin
        if (sign_bit) begin
            shaped = (MID - SW'(1)) - SW'(rom_data);
        end else begin
            shaped = MID + SW'(rom_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample <= MID;
        end else begin
            case (mode)
                dds_pkg::OUT_RUN: sample <= shaped;
                default:          sample <= MID;
            endcase
        end
    end
endmodule

// File: rtl/dds_sine_core.sv
module dds_sine_core #(
    parameter int ACC_W  = dds_pkg::ACC_W,
    parameter int WORD_W = dds_pkg::WORD_W,
    parameter int ROM_AW = dds_pkg::ROM_AW,
    parameter int ROM_DW = dds_pkg::ROM_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] tune_word,
    input  logic              sync_n,
    input  logic              shutdown,
    output logic              clk_half,
    output logic [ROM_DW:0]   sample
);
    localparam int TOP_W = ROM_AW + 2;

    logic               div_q;
    logic [ACC_W-1:0]   phase_q;
    logic [ROM_AW-1:0]  rom_addr;
    logic [ROM_DW-1:0]  rom_data;
    dds_pkg::out_mode_e mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= 1'b0;
        end else begin
            div_q <= ~div_q;
        end
    end
    assign clk_half = div_q;

    always_comb begin
        if (!sync_n) begin
            mode = dds_pkg::OUT_SYNC;
        end else if (shutdown) begin
            mode = dds_pkg::OUT_SHDN;
        end else begin
            mode = dds_pkg::OUT_RUN;
        end
    end

    phase_accum #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .clear   (!sync_n),
        .hold    (shutdown),
        .step_en (div_q),
        .word    (tune_word),
        .phase   (phase_q)
    );

    quarter_rom #(.AW(ROM_AW), .DW(ROM_DW)) u_rom (
        .addr (rom_addr),
        .data (rom_data)
    );

    sine_shaper #(.AW(ROM_AW), .DW(ROM_DW)) u_shaper (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .phase_top (phase_q[ACC_W-1 -: TOP_W]),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data),
        .sample    (sample)
    );
endmodule

// File: rtl/dds_sine_core_chk.sv
module dds_sine_core_chk #(
    parameter int ACC_W  = dds_pkg::ACC_W,
    parameter int SW     = dds_pkg::ROM_DW + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             sync_n,
    input logic             shutdown,
    input logic             clk_half,
    input logic [SW-1:0]    sample,
    input logic [ACC_W-1:0] phase
);
    localparam logic [SW-1:0] MID = SW'(1 << (SW - 1));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (sample == MID && !clk_half && phase == '0));

    // R2
    half_clock_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (clk_half != $past(clk_half)));

    // R3
    idle_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_n && !clk_half) |=> $stable(phase));

    // R5
    sign_half_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_n && !shutdown) |=> (sample[SW-1] == !$past(phase[ACC_W-1])));

    // R6
    sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !sync_n |=> (phase == '0 && sample == MID));

    // R7
    shutdown_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_n && shutdown) |=> ($stable(phase) && sample == MID));

    // R8
    sync_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_n && shutdown) |=> (phase == '0));
endmodule

bind dds_sine_core dds_sine_core_chk #(.ACC_W(ACC_W), .SW(ROM_DW + 1)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sync_n   (sync_n),
    .shutdown (shutdown),
    .clk_half (clk_half),
    .sample   (sample),
    .phase    (phase_q)
);

// File: tb/test_dds_sine_core.sv
module test_dds_sine_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tune_word = 16'd0;
    logic        sync_n = 1'b1;
    logic        shutdown = 1'b0;
    logic        clk_half;
    logic [7:0]  sample;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string req = "R1";

    int exp_phase = 0;
    int exp_div = 0;
    int exp_sample = 128;

    always #2 clk = ~clk;

    dds_sine_core i_dds_sine_core (
        .clk       (clk),
        .rst       (rst),
        .tune_word (tune_word),
        .sync_n    (sync_n),
        .shutdown  (shutdown),
        .clk_half  (clk_half),
        .sample    (sample)
    );

    function automatic int ref_sample(int p);
        int  s;
        int  q;
        int  a;
        int  v;
        real x;
        s = (p >> 20) & 1;
        q = (p >> 19) & 1;
        a = (p >> 12) & 127;
        if (q != 0) a = 127 - a;
        x = (real'(a) + 0.5) * 3.14159265358979 / 256.0;
        v = $rtoi(127.0 * $sin(x) + 0.5);
        return (s != 0) ? (127 - v) : (128 + v);
    endfunction

    task automatic chk(string r, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", r, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Behavioural reference, advanced on every rising edge and compared after it.
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            exp_phase  = 0;
            exp_div    = 0;
            exp_sample = 128;
        end else begin
            if (!sync_n || shutdown) exp_sample = 128;
            else                     exp_sample = ref_sample(exp_phase);
            if (!sync_n)                        exp_phase = 0;
            else if (!shutdown && exp_div == 1) exp_phase = (exp_phase + int'(tune_word)) % (1 << 21);
            exp_div = 1 - exp_div;
        end
        #1;
        chk(req, "sample", int'(sample), exp_sample);
        chk((req == "R1") ? "R1" : "R2", "clk_half", int'(clk_half), exp_div);
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic run(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        req = "R1";
        run(4);
        rst = 1'b0;
        run(2);
        // R3: slow word, steps every second clock
        req = "R3"; tune_word = 16'd1000; run(300);
        // R4 and R5: one table index per step, a full 512-point sweep
        req = "R4"; tune_word = 16'd4096; run(600);
        req = "R5"; run(500);
        // R9: largest word, many wraps
        req = "R9"; tune_word = 16'hFFFF; run(600);
        // R6: hold sync low, then restart from zero
        req = "R6"; tune_word = 16'd3000; run(37);
        sync_n = 1'b0; run(5);
        sync_n = 1'b1; run(200);
        // R7: freeze and resume with the last word
        req = "R7"; shutdown = 1'b1; run(21);
        shutdown = 1'b0; run(200);
        // R8: sync while shut down, released at shifted offsets
        req = "R8";
        for (int off = 0; off < 4; off++) begin
            shutdown = 1'b1; run(3 + off);
            sync_n = 1'b0; run(1 + off);
            sync_n = 1'b1; run(2);
            shutdown = 1'b0; run(40);
            sync_n = 1'b0; run(1);
            sync_n = 1'b1; run(30 + off);
        end
        // R6: single-cycle sync pulses landing on both edge kinds
        req = "R6";
        for (int off = 0; off < 4; off++) begin
            sync_n = 1'b0; run(1);
            sync_n = 1'b1; run(25 + off);
        end
        req = "R1";
        rst = 1'b1; run(3);
        finish_run();
    end
endmodule